// File: doc/BRIEF.md
# Timer-Synchronized Nibble Pulse Output

This block drives an 8-bit general-purpose port made of two 4-bit channels. Software places the next pattern in a staging buffer. Each channel has its own timer strobe. When the strobe arrives, the channel copies its staged nibble into a bank of output flip-flops. The pins therefore change only in step with the timer, and never at the moment software writes the buffer.

Each channel has an enable bit. When the enable bit is clear, that nibble behaves as an ordinary port: a latch supplies the output value and a direction register decides whether each pin is driven. Writes to the register bus take effect at the next clock edge. The bus has no back-pressure and accepts a write on every cycle. Reads are combinational.

Top module: `rtp_nibble_out`

## Requirements
- R1: After reset, every register (port latch, direction, staging buffer, enables) holds 0. As a result, `pin_oe` is 0 and `pin_out` is 0.
- R2: `pin_oe[i]` equals bit i of the direction register (register select 1), where 1 means output. The direction bit controls the pin whether or not the pin's channel is enabled.
- R3: While a channel's enable bit is 0, its four `pin_out` bits equal the matching bits of the port latch (register select 0). A timer strobe on that channel leaves the pins unchanged.
- R4: A strobe on `tick[c]` loads the channel's flip-flops from the staging buffer at that clock edge, whether or not the channel is enabled. While the channel is enabled, each of its pins whose direction bit is 1 shows the flip-flop value.
- R5: A write to the staging buffer (register select 2) does not change `pin_out`.
- R6: If a strobe and a staging-buffer write happen in the same cycle, the pins take the old buffered value. The new value is kept for the next strobe.
- R7: `tick[0]` loads only channel 0, which is port bits 3:0 and staging bits 3:0. `tick[1]` loads only channel 1, which is port bits 7:4 and staging bits 7:4.
- R8: In an enabled channel, a pin whose direction bit is 0 is not driven (`pin_oe` is 0), and its `pin_out` shows the port latch bit.
- R9: Reading through `rd_addr` returns the following:
  - Select 1 returns the direction register.
  - Select 2 returns the staging buffer, not the pin value.
  - Select 3 returns the enables in bits 1:0, with the upper bits 0. Enable bit c belongs to channel c.
  - Select 0 returns `pin_in` for pins set as inputs and the latch for pins set as outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 2 | Per-channel timer underflow strobes |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The bench first writes the staging buffer without a strobe and checks that the pins keep their value. A design that wrote straight through to the pins would fail this check. It then issues a buffer write and a strobe in the same cycle and expects the old value on the pins. A design that forwarded the new data would show the new pattern one strobe too early. Strobing one channel at a time catches a design that crosses or shares the strobes. Mixed direction and enable settings, together with buffer readback after a strobe, catch a design that returns the flip-flops instead of the buffer, or that drives an input pin from the timed data.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_STAGE = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtp_regs.sv
module rtp_regs #(
  parameter int NIB_W  = 4,
  parameter int NUM_CH = 2,
  localparam int PORT_W = NIB_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] stage_q,
  output logic [NUM_CH-1:0] ctrl_q
);
  import rtp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      stage_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_LATCH: latch_q <= wr_data;
        SEL_DIR:   dir_q   <= wr_data;
        SEL_STAGE: stage_q <= wr_data;
        SEL_CTRL:  ctrl_q  <= wr_data[NUM_CH-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      SEL_LATCH: rd_data = (dir_q & latch_q) | (~dir_q & pin_in);
      SEL_DIR:   rd_data = dir_q;
      SEL_STAGE: rd_data = stage_q;
      SEL_CTRL:  rd_data[NUM_CH-1:0] = ctrl_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtp_channel.sv
module rtp_channel #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [NIB_W-1:0] stage_nib,
  input  logic [NIB_W-1:0] dir_nib,
  input  logic [NIB_W-1:0] latch_nib,
  output logic [NIB_W-1:0] pin_nib
);
  logic [NIB_W-1:0] timed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      timed_q <= '0;
    else if (tick)
      timed_q <= stage_nib;
  end

  always_comb begin
    for (int b = 0; b < NIB_W; b++)
      pin_nib[b] = (enable && dir_nib[b]) ? timed_q[b] : latch_nib[b];
  end
endmodule

// File: rtl/rtp_nibble_out.sv
module rtp_nibble_out #(
  parameter int NIB_W  = 4,
  parameter int NUM_CH = 2,
  localparam int PORT_W = NIB_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [PORT_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] tick,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] stage_q;
  logic [NUM_CH-1:0] ctrl_q;

  rtp_regs #(.NIB_W(NIB_W), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .pin_in(pin_in),
    .rd_data(rd_data), .latch_q(latch_q), .dir_q(dir_q),
    .stage_q(stage_q), .ctrl_q(ctrl_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rtp_channel #(.NIB_W(NIB_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick[c]), .enable(ctrl_q[c]),
      .stage_nib(stage_q[c*NIB_W +: NIB_W]),
      .dir_nib(dir_q[c*NIB_W +: NIB_W]),
      .latch_nib(latch_q[c*NIB_W +: NIB_W]),
      .pin_nib(pin_out[c*NIB_W +: NIB_W])
    );
  end

  assign pin_oe = dir_q;
endmodule

// File: rtl/rtp_nibble_out_chk.sv
module rtp_nibble_out_chk #(
  parameter int NIB_W  = 4,
  parameter int NUM_CH = 2,
  localparam int PORT_W = NIB_W * NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [PORT_W-1:0] wr_data,
  input logic [NUM_CH-1:0] tick,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] latch_q,
  input logic [PORT_W-1:0] stage_q,
  input logic [NUM_CH-1:0] ctrl_q
);
  logic cfg_wr;
  assign cfg_wr = wr_en && (wr_addr != 2'd2);

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> pin_oe == $past(wr_data)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_OFF_SHOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[c] |-> pin_out[c*NIB_W +: NIB_W] == latch_q[c*NIB_W +: NIB_W]); // R3
    AST_TICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && ctrl_q[c] && &pin_oe[c*NIB_W +: NIB_W] && !cfg_wr)
      |=> pin_out[c*NIB_W +: NIB_W] == $past(stage_q[c*NIB_W +: NIB_W])); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[c] && !cfg_wr) |=> $stable(pin_out[c*NIB_W +: NIB_W])); // R5
    AST_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && wr_en && wr_addr == 2'd2 && ctrl_q[c] && &pin_oe[c*NIB_W +: NIB_W])
      |=> pin_out[c*NIB_W +: NIB_W] == $past(stage_q[c*NIB_W +: NIB_W])); // R6
  end
endmodule

bind rtp_nibble_out rtp_nibble_out_chk #(.NIB_W(NIB_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tick(tick), .pin_out(pin_out), .pin_oe(pin_oe), .latch_q(latch_q),
  .stage_q(stage_q), .ctrl_q(ctrl_q)
);

// File: tb/rtp_nibble_out_test.sv
`timescale 1ns/1ps
module rtp_nibble_out_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] tick = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtp_nibble_out uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one bus cycle: optional write plus strobes, applied for one clock edge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d, input logic [1:0] t);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 0; tick = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 readback", v, 8'h00);
    end
  endtask

  task automatic t_dir;
    logic [7:0] v;
    cyc(1, 2'd1, 8'hA5, 2'b00);
    check("R2 oe", pin_oe, 8'hA5);
    rd(2'd1, v);
    check("R9 dir read", v, 8'hA5);
  endtask

  task automatic t_disabled;
    cyc(1, 2'd0, 8'h3C, 2'b00);
    cyc(1, 2'd1, 8'hFF, 2'b00);
    check("R3 latch out", pin_out, 8'h3C);
    cyc(1, 2'd2, 8'h99, 2'b00);
    cyc(0, 2'd0, 8'h00, 2'b11);
    check("R3 tick ignored", pin_out, 8'h3C);
  endtask

  task automatic t_stage_write;
    logic [7:0] v;
    cyc(1, 2'd3, 8'h03, 2'b00);
    check("R4 enabled shows timed", pin_out, 8'h99);
    cyc(1, 2'd2, 8'h12, 2'b00);
    check("R5 write no effect", pin_out, 8'h99);
    rd(2'd2, v);
    check("R9 stage read", v, 8'h12);
  endtask

  task automatic t_independent;
    cyc(0, 2'd0, 8'h00, 2'b01);
    check("R7 tick0 only low", pin_out, 8'h92);
    cyc(0, 2'd0, 8'h00, 2'b10);
    check("R7 tick1 high", pin_out, 8'h12);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    cyc(1, 2'd2, 8'h47, 2'b11);
    check("R6 old value out", pin_out, 8'h12);
    rd(2'd2, v);
    check("R6 new value kept", v, 8'h47);
    cyc(0, 2'd0, 8'h00, 2'b11);
    check("R4 next tick", pin_out, 8'h47);
  endtask

  task automatic t_mixed;
    logic [7:0] v;
    cyc(1, 2'd1, 8'h0F, 2'b00);
    check("R8 oe", pin_oe, 8'h0F);
    check("R8 input pins show latch", pin_out, 8'h37);
    pin_in = 8'hA5;
    rd(2'd0, v);
    check("R9 port read", v, 8'hAC);
    cyc(1, 2'd1, 8'hFF, 2'b00);
    cyc(1, 2'd3, 8'h02, 2'b00);
    check("R3 ch0 disabled", pin_out, 8'h4C);
    rd(2'd3, v);
    check("R9 ctrl read", v, 8'h02);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_disabled();
    t_stage_write();
    t_independent();
    t_collide();
    t_mixed();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule